// File: doc/BRIEF.md
# Windowed Change Checker

This block is a synthesizable runtime monitor that sits beside a design and watches a multi-bit value. A start pulse opens a time window of a fixed number of clock cycles. The value captured on the opening edge is kept as the reference. If the watched value never differs from that reference on any edge checked inside the window, the block raises a one-cycle error pulse when the window expires. A difference seen on a checked edge satisfies the window, which then closes at once without an error.

A compile-time mode sets how a start that arrives while a window is already open is handled. In ignore mode the window carries on untouched. In error mode the start raises the error pulse and the window carries on. In restart mode the running window is dropped without a check on that edge, and a new window with a fresh reference begins. A window-open status output shows whether a window is running.

Top module: `window_change_checker`

## Requirements
- R1: Reset is synchronous and active low; after a rising clock edge with `rst_n` low, both `win_open` and `fire` are 0.
- R2: When no window is open, an edge with `start_evt` high opens a window: `win_open` reads 1 after that edge, and the `test_val` sampled on that edge becomes the reference.
- R3: `test_val` is not compared on the opening edge, so a value that differs from the previous cycle on that edge only sets the reference and causes neither a close nor an error.
- R4: The edges checked in a window are the NUM_CKS edges after the opening edge, the last one included; if `test_val` differs from the reference on a checked edge, the window closes after that edge (`win_open` reads 0) and `fire` stays 0.
- R5: If `test_val` equals the reference on all NUM_CKS checked edges, then after the last one `win_open` reads 0 and `fire` reads 1 for exactly one cycle.
- R6: In ignore mode (MODE = NS_IGNORE), `start_evt` while a window is open changes neither the reference, the count of checked edges, nor `fire`.
- R7: In error mode (MODE = NS_ERROR), `start_evt` on an edge while a window is open makes `fire` read 1 for the following cycle, and the window keeps its reference and edge count.
- R8: In restart mode (MODE = NS_RESTART), `start_evt` on an edge while a window is open skips the comparison on that edge, takes `test_val` on that edge as the new reference and restarts the count, so the timeout comes NUM_CKS checked edges later.
- R9: `fire` is high only in a cycle that directly follows a cycle in which `win_open` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_evt | input | 1 | Start request, sampled on each rising edge |
| test_val | input | WIDTH | Value watched for a change |
| fire | output | 1 | Registered error pulse |
| win_open | output | 1 | High while a window is running |

## Verification
All three modes are built side by side, fed the same stimulus, and compared against a behavioural model on every cycle. A value that stays constant separates the timeout path from the satisfied path. A change placed on the opening edge shows that the opening edge is excluded. Changes on the second and on the last checked edge show that the closing edge is included. A second start placed mid-window and on the closing edge is what separates ignore, error and restart behaviour. A long stretch of pseudo-random starts with rare value changes then mixes these cases in orderings the directed part does not reach.

// File: rtl/wchk_pkg.sv
// Package: shared types for the windowed change checker.
// Assumes nothing; holds only the handling mode for a start inside a window.
package wchk_pkg;
    typedef enum logic [1:0] {
        NS_IGNORE  = 2'd0,
        NS_ERROR   = 2'd1,
        NS_RESTART = 2'd2
    } ns_mode_e;
endpackage

// File: rtl/wchk_ref.sv
// Module: wchk_ref
// Holds the reference value captured when a window (re)opens and reports
// whether the present input differs from it. Assumes load_ref is asserted
// by the controller on every opening or restarting edge.
module wchk_ref #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_ref,
    input  logic [WIDTH-1:0] test_val,
    output logic             changed
);
    logic [WIDTH-1:0] ref_q;

    // Capture the reference on an opening edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= '0;
        else if (load_ref)
            ref_q <= test_val;
    end

    // Compare the live value against the stored reference.
    always_comb changed = (test_val != ref_q);
endmodule

// File: rtl/wchk_ctrl.sv
// Module: wchk_ctrl
// Two-state window controller (idle / checking) with a counter of checked
// edges. Decides, per edge, whether to open, restart, compare, close or time
// out. Assumes `changed` reflects the reference held by wchk_ref.
module wchk_ctrl #(
    parameter int                 NUM_CKS = 4,
    parameter wchk_pkg::ns_mode_e MODE    = wchk_pkg::NS_IGNORE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_evt,
    input  logic changed,
    output logic win_open,
    output logic load_ref,
    output logic timeout,
    output logic new_start_err
);
    import wchk_pkg::*;

    localparam int            CW   = (NUM_CKS > 1) ? $clog2(NUM_CKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(NUM_CKS - 1);

    typedef enum logic {ST_IDLE = 1'b0, ST_CHECK = 1'b1} st_e;

    st_e           state_q;
    logic [CW-1:0] cnt_q;
    logic          restart;
    logic          check_now;
    logic          last_edge;
    logic          close_now;

    // Per-edge decisions derived from state, mode and inputs.
    always_comb begin
        win_open      = (state_q == ST_CHECK);
        restart       = win_open && start_evt && (MODE == NS_RESTART);
        load_ref      = (!win_open && start_evt) || restart;
        check_now     = win_open && !restart;
        last_edge     = (cnt_q == LAST);
        close_now     = check_now && (changed || last_edge);
        timeout       = check_now && !changed && last_edge;
        new_start_err = win_open && start_evt && (MODE == NS_ERROR);
    end

    // State and checked-edge counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (load_ref) begin
            state_q <= ST_CHECK;
            cnt_q   <= '0;
        end else if (close_now) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (check_now) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    AST_OPEN_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && start_evt) |=> (win_open && cnt_q == '0)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R5

    AST_CHANGE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !start_evt && changed) |=> !win_open); // R4

    AST_TIMEOUT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !win_open); // R5

    generate
        if (MODE == NS_RESTART) begin : g_restart_chk
            AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (win_open && start_evt) |=> (win_open && cnt_q == '0)); // R8
        end
        if (MODE == NS_IGNORE) begin : g_ignore_chk
            AST_IGNORE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (win_open && start_evt && !changed && !last_edge)
                |=> (win_open && cnt_q == $past(cnt_q) + 1'b1)); // R6
        end
    endgenerate
endmodule

// File: rtl/wchk_flag.sv
// Module: wchk_flag
// Registers the error pulse from the controller's timeout and new-start
// error strobes. Assumes both strobes are single-edge decisions.
module wchk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic new_start_err,
    input  logic win_open,
    output logic fire
);
    // One-cycle error register; clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fire <= 1'b0;
        else
            fire <= timeout || new_start_err;
    end

    AST_FIRE_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(win_open)); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!fire && !win_open)); // R1
endmodule

// File: rtl/window_change_checker.sv
// Module: window_change_checker (top)
// Flags an error when a watched value fails to change within NUM_CKS checked
// edges after a start. MODE picks how a start inside an open window is
// handled. Assumes NUM_CKS >= 1, enforced at elaboration.
module window_change_checker #(
    parameter int                 WIDTH   = 8,
    parameter int                 NUM_CKS = 4,
    parameter wchk_pkg::ns_mode_e MODE    = wchk_pkg::NS_IGNORE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  logic [WIDTH-1:0] test_val,
    output logic             fire,
    output logic             win_open
);
    logic load_ref;
    logic changed;
    logic timeout;
    logic new_start_err;

    generate
        if (NUM_CKS < 1) begin : g_bad_cks
            $error("window_change_checker: NUM_CKS must be at least 1");
        end
    endgenerate

    wchk_ref #(.WIDTH(WIDTH)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_ref (load_ref),
        .test_val (test_val),
        .changed  (changed)
    );

    wchk_ctrl #(.NUM_CKS(NUM_CKS), .MODE(MODE)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_evt     (start_evt),
        .changed       (changed),
        .win_open      (win_open),
        .load_ref      (load_ref),
        .timeout       (timeout),
        .new_start_err (new_start_err)
    );

    wchk_flag u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .timeout       (timeout),
        .new_start_err (new_start_err),
        .win_open      (win_open),
        .fire          (fire)
    );
endmodule

// File: tb/window_change_checker_test.sv
`timescale 1ns/1ps
// Bench: three instances, one per mode, fed the same stimulus and compared
// on every clock against a behavioural model.
module window_change_checker_test;
    import wchk_pkg::*;

    localparam int W = 8;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_evt = 1'b0;
    logic [W-1:0] test_val = '0;
    logic         fire_v [3];
    logic         open_v [3];

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // model state per mode: 0 ignore, 1 error, 2 restart
    bit          m_open [3];
    bit          m_fire [3];
    int          m_age  [3];
    logic [W-1:0] m_ref [3];

    always #4 clk = ~clk;

    window_change_checker #(.WIDTH(W), .NUM_CKS(N), .MODE(NS_IGNORE)) uut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .test_val(test_val),
        .fire(fire_v[0]), .win_open(open_v[0]));
    window_change_checker #(.WIDTH(W), .NUM_CKS(N), .MODE(NS_ERROR)) uut_err (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .test_val(test_val),
        .fire(fire_v[1]), .win_open(open_v[1]));
    window_change_checker #(.WIDTH(W), .NUM_CKS(N), .MODE(NS_RESTART)) uut_rst (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .test_val(test_val),
        .fire(fire_v[2]), .win_open(open_v[2]));

    // behavioural expectation, advanced on each rising edge
    always @(posedge clk) begin
        cycles++;
        for (int m = 0; m < 3; m++) begin
            m_fire[m] = 0;
            if (!rst_n) begin
                m_open[m] = 0;
                m_age[m]  = 0;
            end else if (!m_open[m]) begin
                if (start_evt) begin
                    m_open[m] = 1; m_ref[m] = test_val; m_age[m] = 0;
                end
            end else if (start_evt && m == 2) begin
                m_ref[m] = test_val; m_age[m] = 0;
            end else begin
                if (start_evt && m == 1) m_fire[m] = 1;
                m_age[m] = m_age[m] + 1;
                if (test_val !== m_ref[m]) m_open[m] = 0;
                else if (m_age[m] == N) begin
                    m_open[m] = 0; m_fire[m] = 1;
                end
            end
        end
    end

    // compare every instance away from the active edge
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            for (int m = 0; m < 3; m++) begin
                checks++;
                if (fire_v[m] !== m_fire[m] || open_v[m] !== m_open[m]) begin
                    errors++;
                    $display("FAIL %s mode%0d cycle %0d: fire=%0b open=%0b expected fire=%0b open=%0b",
                             cur_req, m, cycles, fire_v[m], open_v[m], m_fire[m], m_open[m]);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input bit s, input logic [W-1:0] v);
        @(negedge clk);
        start_evt = s;
        test_val  = v;
    endtask

    task automatic idle_out(input logic [W-1:0] v);
        for (int i = 0; i < N + 3; i++) step(0, v);
    endtask

    initial begin
        // R1: reset clears outputs
        cur_req = "R1";
        step(0, 8'h00); step(1, 8'h11); step(0, 8'h11);
        rst_n = 1'b1;
        step(1, 8'h05); step(0, 8'h05);
        rst_n = 1'b0;
        step(0, 8'h05); step(0, 8'h05);
        rst_n = 1'b1;
        step(0, 8'h05);

        // R2, R5: constant value times out
        cur_req = "R5";
        step(1, 8'h05);
        idle_out(8'h05);

        // R3: value changes exactly on the opening edge
        cur_req = "R3";
        step(0, 8'h20);
        step(1, 8'h21);
        idle_out(8'h21);

        // R4: change on second checked edge
        cur_req = "R4";
        step(1, 8'h30); step(0, 8'h30); step(0, 8'h31);
        idle_out(8'h31);

        // R4: change on last checked edge (closing edge included)
        cur_req = "R4";
        step(1, 8'h40);
        for (int i = 0; i < N - 1; i++) step(0, 8'h40);
        step(0, 8'h41);
        idle_out(8'h41);

        // R6, R7, R8: second start mid-window, value constant
        cur_req = "R7";
        step(1, 8'h50); step(0, 8'h50); step(1, 8'h50);
        idle_out(8'h50);
        idle_out(8'h50);

        // R8: restart with a new value, then no change
        cur_req = "R8";
        step(1, 8'h60); step(0, 8'h60); step(1, 8'h61);
        idle_out(8'h61);
        idle_out(8'h61);

        // R6: second start lands on the closing edge, then right after
        cur_req = "R6";
        step(1, 8'h70);
        for (int i = 0; i < N - 1; i++) step(0, 8'h70);
        step(1, 8'h70);
        step(1, 8'h70);
        idle_out(8'h70);
        idle_out(8'h70);

        // R9: mixed pseudo-random traffic
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            bit s;
            logic [W-1:0] v;
            s = (($urandom % 5) == 0);
            v = (($urandom % 7) == 0) ? W'($urandom) : test_val;
            step(s, v);
        end
        idle_out(test_val);
        idle_out(test_val);

        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule